// File: doc/BRIEF.md
# Parallel DAC Front-End with Power-Mode Control

This block is the digital side of a parallel-input, video-rate digital-to-analog converter. A data word is captured into an input register on a rising clock edge. One edge later it moves into a converter register whose contents drive the analog switch code. Loading is gated by an active-low select. A low-power request and an enable input choose between running, standby and shutdown. The block turns that choice into enables for the reference, the control amplifier and the current array. It reports the mode and tells the output stage whether to float or to clamp to ground.

Leaving standby or shutdown starts a settle interval, counted in clock cycles. The output-valid flag stays low until that interval is over. While the block is not asked to run, both data registers are frozen. When it comes back, the converter therefore resumes with the code it held before it slept. The analog stage is outside the block, and only its control signals are produced here.

Top module: `dac_frontend`

## Requirements
- R1: While the block is asked to run (`pd_sel`=0, `dac_on`=1) and `cs_n`=0, `din` is stored in the input register at a rising edge, and `code_out` shows that value after the next rising edge, which is two edges after it was presented.
- R2: While `cs_n`=1 the input register keeps its value, so `code_out` keeps showing the last word that was loaded.
- R3: After an edge at which `pd_sel`=1, `mode_st` is 2'b00 (shutdown) and `ref_en`, `amp_en` and `arr_en` are all 0, whatever `dac_on` is.
- R4: After an edge at which `pd_sel`=0 and `dac_on`=0, `mode_st` is 2'b01 (standby), `ref_en`=1, `amp_en`=1 and `arr_en`=0.
- R5: After an edge at which the block is asked to run while in standby or shutdown, `mode_st` is 2'b10 (waking) for exactly SETTLE_CYC cycles and then 2'b11 (active). `code_valid` is 1 only in the active mode.
- R6: If the run request is withdrawn during waking, the settle count is discarded, and the next run request starts a fresh count of SETTLE_CYC cycles.
- R7: While the block is not asked to run, neither data register changes. After returning, `code_out` equals the code it held before leaving.
- R8: In shutdown and standby, `out_hiz`=1 and `out_gnd`=0 when VOLTAGE_OUT=0, or `out_hiz`=0 and `out_gnd`=1 when VOLTAGE_OUT=1. In waking and active, both are 0.
- R9: A synchronous reset (`rst_n`=0 at an edge) gives `mode_st`=2'b00, `code_out`=0, `code_valid`=0 and all enables 0.
- R10: In waking and in active, `ref_en`, `amp_en` and `arr_en` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Load select, active low |
| pd_sel | input | 1 | 1 requests shutdown |
| dac_on | input | 1 | With `pd_sel`=0: 1 run, 0 standby |
| din | input | DW | Parallel data word |
| code_out | output | DW | Converter register contents |
| code_valid | output | 1 | Output settled and valid |
| mode_st | output | 2 | 00 shutdown, 01 standby, 10 waking, 11 active |
| ref_en | output | 1 | Reference enable |
| amp_en | output | 1 | Control amplifier enable |
| arr_en | output | 1 | Current array enable |
| out_hiz | output | 1 | Output stage floats |
| out_gnd | output | 1 | Output stage clamped to ground |

## Verification
The bench withdraws the run request partway through the settle count. A design that resumes the old count instead of restarting it raises `code_valid` early. It also parks the block in standby while `din` keeps changing, and then wakes it. A design that lets either register move during sleep comes back with the wrong code. Holding `cs_n` high while data changes catches an input register that ignores the select. Off-by-one errors in the settle window show up as `code_valid` rising one cycle early or late. A second instance built for voltage output catches flags that are swapped between the two output variants.

// File: rtl/dacfe_pkg.sv
// Package: shared mode encoding for the DAC front-end.
// Assumes: the two-bit code values are visible at the top-level mode output.
package dacfe_pkg;
    typedef enum logic [1:0] {
        PM_SHUT = 2'b00,
        PM_STBY = 2'b01,
        PM_WAKE = 2'b10,
        PM_RUN  = 2'b11
    } pmode_t;
endpackage

// File: rtl/dacfe_pipe.sv
// Module: two-stage data path (input register, then converter register).
// Assumes: adv_en is high only while a run is requested; load_en implies adv_en.
module dacfe_pipe #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          adv_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] in_q,
    output logic [DW-1:0] code_q
);
    // Capture stage: takes the bus when selected and running.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_q <= '0;
        else if (load_en) in_q <= din;
    end

    // Converter stage: follows the capture stage one edge later while running.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (adv_en) code_q <= in_q;
    end
endmodule

// File: rtl/dacfe_power.sv
// Module: power-mode sequencer with counted wake-up settle interval.
// Assumes: pd_sel and dac_on are synchronous to clk; SETTLE_CYC >= 1.
module dacfe_power
    import dacfe_pkg::*;
#(
    parameter int SETTLE_CYC = 2500
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pd_sel,
    input  logic   dac_on,
    output pmode_t mode,
    output logic   ref_en,
    output logic   amp_en,
    output logic   arr_en,
    output logic   valid
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    pmode_t        st;
    logic [CW-1:0] cnt;

    // Mode register and settle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PM_SHUT;
            cnt <= '0;
        end else if (pd_sel) begin
            st  <= PM_SHUT;
            cnt <= '0;
        end else if (!dac_on) begin
            st  <= PM_STBY;
            cnt <= '0;
        end else begin
            case (st)
                PM_SHUT, PM_STBY: begin
                    st  <= PM_WAKE;
                    cnt <= '0;
                end
                PM_WAKE: begin
                    if (cnt == LAST) st <= PM_RUN;
                    else             cnt <= cnt + 1'b1;
                end
                default: st <= PM_RUN;
            endcase
        end
    end

    // Enable decode from the registered mode.
    always_comb begin
        mode   = st;
        ref_en = (st != PM_SHUT);
        amp_en = (st != PM_SHUT);
        arr_en = st[1];
        valid  = (st == PM_RUN);
    end
endmodule

// File: rtl/dacfe_outstate.sv
// Module: output-stage idle indication, variant picked by VOLTAGE_OUT.
// Assumes: mode bit 1 is set exactly in waking and active.
module dacfe_outstate
    import dacfe_pkg::*;
#(
    parameter bit VOLTAGE_OUT = 1'b0
) (
    input  pmode_t mode,
    output logic   hiz,
    output logic   gnd
);
    logic idle;
    assign idle = ~mode[1];

    generate
        if (VOLTAGE_OUT) begin : g_volt
            assign gnd = idle;
            assign hiz = 1'b0;
        end else begin : g_curr
            assign hiz = idle;
            assign gnd = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dac_frontend.sv
// Module: top of the DAC front-end; data pipeline, power sequencer, output state.
// Assumes: all inputs synchronous to clk; analog stage consumes the enables.
module dac_frontend
    import dacfe_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SETTLE_CYC  = 2500,
    parameter bit VOLTAGE_OUT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          pd_sel,
    input  logic          dac_on,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] code_out,
    output logic          code_valid,
    output logic [1:0]    mode_st,
    output logic          ref_en,
    output logic          amp_en,
    output logic          arr_en,
    output logic          out_hiz,
    output logic          out_gnd
);
    logic          run_req;
    logic [DW-1:0] in_q;
    pmode_t        mode;

    // Run request straight from the control pins.
    assign run_req = ~pd_sel & dac_on;

    dacfe_pipe #(.DW(DW)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (run_req & ~cs_n),
        .adv_en  (run_req),
        .din     (din),
        .in_q    (in_q),
        .code_q  (code_out)
    );

    dacfe_power #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_sel (pd_sel),
        .dac_on (dac_on),
        .mode   (mode),
        .ref_en (ref_en),
        .amp_en (amp_en),
        .arr_en (arr_en),
        .valid  (code_valid)
    );

    dacfe_outstate #(.VOLTAGE_OUT(VOLTAGE_OUT)) u_ost (
        .mode (mode),
        .hiz  (out_hiz),
        .gnd  (out_gnd)
    );

    assign mode_st = mode;
endmodule

// File: rtl/dacfe_chk.sv
// Module: property checker for the DAC front-end, bound into every instance.
// Assumes: sampled on the same clock and reset as the top.
module dacfe_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          pd_sel,
    input logic          dac_on,
    input logic [DW-1:0] in_q,
    input logic [DW-1:0] code_out,
    input logic          code_valid,
    input logic [1:0]    mode_st,
    input logic          ref_en,
    input logic          amp_en,
    input logic          arr_en,
    input logic          out_hiz,
    input logic          out_gnd
);
    // R1
    pipe_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_sel && dac_on) |=> code_out == $past(in_q));
    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || pd_sel || !dac_on) |=> $stable(in_q));
    // R3
    shut_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_sel |=> (mode_st == 2'b00 && !ref_en && !amp_en && !arr_en));
    // R4
    stby_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_sel && !dac_on) |=> (mode_st == 2'b01 && ref_en && amp_en && !arr_en));
    // R5
    valid_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(mode_st) == 2'b10);
    // R6
    wake_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'b10 && (pd_sel || !dac_on)) |=> mode_st != 2'b10);
    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_sel || !dac_on) |=> $stable(code_out));
    // R8
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_st[1] |-> $onehot({out_hiz, out_gnd}));
    // R8
    live_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_st[1] |-> (!out_hiz && !out_gnd));
    // R10
    live_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_st[1] |-> (ref_en && amp_en && arr_en));
endmodule

bind dac_frontend dacfe_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .pd_sel     (pd_sel),
    .dac_on     (dac_on),
    .in_q       (in_q),
    .code_out   (code_out),
    .code_valid (code_valid),
    .mode_st    (mode_st),
    .ref_en     (ref_en),
    .amp_en     (amp_en),
    .arr_en     (arr_en),
    .out_hiz    (out_hiz),
    .out_gnd    (out_gnd)
);

// File: tb/dac_frontend_bench.sv
// Bench: directed corner cases plus seeded random control/data, checked
// against a requirement-level model advanced once per clock.
module dac_frontend_bench;
    localparam int DW = 8;
    localparam int S  = 6;

    logic          clk = 1'b0;
    logic          rst_n, cs_n, pd_sel, dac_on;
    logic [DW-1:0] din;
    logic [DW-1:0] code_out, code_v;
    logic          code_valid, ref_en, amp_en, arr_en, out_hiz, out_gnd;
    logic [1:0]    mode_st, mode_v;
    logic          valid_v, ref_v, amp_v, arr_v, hiz_v, gnd_v;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [DW-1:0] m_in, m_code;
    int            m_st, m_cnt;
    string         ctag = "R1";
    string         mtag = "";

    always #10 clk = ~clk;

    dac_frontend #(.DW(DW), .SETTLE_CYC(S), .VOLTAGE_OUT(1'b0)) u_dac_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pd_sel(pd_sel), .dac_on(dac_on),
        .din(din), .code_out(code_out), .code_valid(code_valid), .mode_st(mode_st),
        .ref_en(ref_en), .amp_en(amp_en), .arr_en(arr_en),
        .out_hiz(out_hiz), .out_gnd(out_gnd));

    dac_frontend #(.DW(DW), .SETTLE_CYC(S), .VOLTAGE_OUT(1'b1)) u_dac_frontend_v (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pd_sel(pd_sel), .dac_on(dac_on),
        .din(din), .code_out(code_v), .code_valid(valid_v), .mode_st(mode_v),
        .ref_en(ref_v), .amp_en(amp_v), .arr_en(arr_v),
        .out_hiz(hiz_v), .out_gnd(gnd_v));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input int st);
        if (mtag != "") return mtag;
        case (st)
            0: return "R3";
            1: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Compare both instances against the model.
    task automatic compare();
        int idle;
        idle = (m_st < 2);
        chk(ctag, code_out, m_code);
        chk(mode_tag(m_st), mode_st, m_st);
        chk("R5", code_valid, m_st == 3);
        chk(m_st >= 2 ? "R10" : mode_tag(m_st), {ref_en, amp_en, arr_en},
            m_st == 0 ? 0 : (m_st == 1 ? 3'b110 : 3'b111));
        chk("R8", {out_hiz, out_gnd}, idle ? 2'b10 : 2'b00);
        chk("R8", {hiz_v, gnd_v}, idle ? 2'b01 : 2'b00);
        chk(mode_tag(m_st), mode_v, m_st);
    endtask

    // Advance the model across the coming rising edge.
    task automatic model_step();
        bit run;
        run = !pd_sel && dac_on;
        if (!rst_n) begin
            m_in = '0; m_code = '0; m_st = 0; m_cnt = 0;
        end else begin
            if (run) begin
                m_code = m_in;
                if (!cs_n) m_in = din;
            end
            if (pd_sel)       begin m_st = 0; m_cnt = 0; end
            else if (!dac_on) begin m_st = 1; m_cnt = 0; end
            else if (m_st < 2) begin m_st = 2; m_cnt = 0; end
            else if (m_st == 2) begin
                if (m_cnt == S - 1) m_st = 3;
                else m_cnt++;
            end
        end
    endtask

    task automatic cyc(input bit r, input bit pd, input bit en, input bit cs,
                       input logic [DW-1:0] d);
        @(negedge clk);
        compare();
        rst_n = r; pd_sel = pd; dac_on = en; cs_n = cs; din = d;
        model_step();
    endtask

    initial begin
        rst_n = 1'b0; pd_sel = 1'b0; dac_on = 1'b1; cs_n = 1'b0; din = 8'h11;
        m_in = '0; m_code = '0; m_st = 0; m_cnt = 0;
        void'($urandom(32'd4242));
        @(negedge clk);
        model_step();
        repeat (2) cyc(0, 0, 1, 0, 8'hEE);
        // R9: reset state
        @(negedge clk);
        chk("R9", {mode_st, code_valid, ref_en, amp_en, arr_en}, 0);
        chk("R9", code_out, 0);
        rst_n = 1'b1;
        model_step();
        // R5 wake from shutdown, R1 loading
        for (int i = 0; i < S + 4; i++) cyc(1, 0, 1, 0, 8'(8'h20 + i));
        cyc(1, 0, 1, 0, 8'hA5);
        cyc(1, 0, 1, 0, 8'hA5);
        // R2 select high, bus changes
        ctag = "R2";
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, 8'(8'h3C + i));
        chk("R2", code_out, 8'hA5);
        // R7 standby hold and restore
        ctag = "R1";
        cyc(1, 0, 1, 0, 8'h77);
        cyc(1, 0, 1, 0, 8'h77);
        ctag = "R7";
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 8'(i * 13));
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, 8'(i * 7));
        cyc(1, 0, 1, 1, 8'h00);
        @(negedge clk);
        chk("R7", code_out, 8'h77);
        chk("R5", mode_st, 2'b10);
        // R6 abort mid-count then restart
        mtag = "R6";
        for (int i = 0; i < 2; i++) cyc(1, 0, 1, 1, 8'h00);
        cyc(1, 0, 0, 1, 8'h00);
        for (int i = 0; i < S + 3; i++) cyc(1, 0, 1, 1, 8'h00);
        mtag = "";
        ctag = "R1";
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit pd, en, cs;
            pd = ($urandom % 16) == 0;
            en = ($urandom % 8) != 0;
            cs = ($urandom % 4) == 0;
            cyc(1, pd, en, cs, 8'($urandom));
        end
        cyc(1, 0, 1, 0, 8'h00);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule